// File: doc/BRIEF.md
# Per-Channel Video Detect Status Tracker

This block follows the video-detect flag that arrives with every metadata header of a line-multiplexed stream carrying embedded sync. A header parser upstream presents a one-cycle strobe together with a 5-bit source number and the detect flag. The tracker stores the flag in one bit of a 32-bit status word. The bit is chosen by the source number. Whenever the stored bit for that channel changes value, the tracker raises a single-cycle interrupt.

A configuration input selects narrow channel numbering. When it is set, the two upper bits of the source field are treated as reserved and dropped, so only eight channels can be addressed. A mode-enable input gates all updates, because the flag carries meaning only in the line-multiplexed embedded-sync mode. Each pixel clock domain instantiates its own tracker, and each instance has its own status word and interrupt.

Top module: `vdet_status_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears every bit of `status_o` to 0 and drives `irq_o` low.
- R2: When `meta_valid` and `mode_en` are both high at a clock edge, status bit N (bit N of `status_o`, LSB is bit 0) takes the value of `meta_flag` from the cycle after that edge, where N is the decoded channel index.
- R3: An accepted strobe changes no status bit other than the addressed one.
- R4: `irq_o` is high for the cycle after an accepted strobe whose `meta_flag` differs from the stored bit of the addressed channel.
- R5: An accepted strobe whose `meta_flag` equals the stored bit leaves `irq_o` low in the following cycle.
- R6: While `mode_en` is low, a strobe is ignored: `status_o` keeps its value and `irq_o` stays low.
- R7: When `narrow_id` is 1, the channel index is `meta_src[2:0]` and `meta_src[4:3]` are ignored, so only bits 7..0 of `status_o` can change.
- R8: When `narrow_id` is 0, the channel index is the full 5-bit value of `meta_src`, so every one of bits 0..31 can be reached.
- R9: In a cycle without an accepted strobe, `status_o` holds and `irq_o` is low in the next cycle. `irq_o` is therefore a pulse of one cycle unless the next strobe also changes a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_en | input | 1 | Line-multiplexed embedded-sync mode enable; gates all updates |
| narrow_id | input | 1 | 1: use only the low 3 bits of the source number |
| meta_valid | input | 1 | One-cycle strobe marking a decoded metadata header |
| meta_src | input | 5 | Source number from the header |
| meta_flag | input | 1 | Video-detect flag from the header |
| status_o | output | 32 | Latest detect flag per channel, bit N for channel N |
| irq_o | output | 1 | Change interrupt, one cycle after the causing strobe |

## Verification
The bench targets source numbers whose upper bits are set while narrow numbering is on. A decoder that ignored `narrow_id` would write bits 8..31 there, and one that always masked would never reach them. It sends repeated strobes that carry the same flag, to catch an interrupt raised on every update instead of only on a change. It also sends back-to-back strobes that toggle the same channel, to catch a comparison made against a stale stored value. Strobes sent with `mode_en` low must leave both the status word and the interrupt untouched. Reset is applied again halfway through the run with bits set, which exposes a status bank that clears only part of the word.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
    parameter int SRC_W    = 5;
    parameter int NARROW_W = 3;
    localparam int NUM_CH  = 1 << SRC_W;

    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [NUM_CH-1:0] chvec_t;

    typedef struct packed {
        chvec_t status;
    } bank_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;
endpackage

// File: rtl/vdet_src_decode.sv
module vdet_src_decode
    import vdet_pkg::*;
(
    input  logic   narrow_id,
    input  src_t   src_i,
    output src_t   idx_o,
    output chvec_t sel_o
);
    src_t idx;

    generate
        if (NARROW_W < SRC_W) begin : g_mask
            always_comb begin
                idx = src_i;
                if (narrow_id) begin
                    idx[SRC_W-1:NARROW_W] = '0;
                end
            end
        end else begin : g_nomask
            always_comb idx = src_i;
        end
    endgenerate

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_sel
            assign sel_o[ch] = (idx == src_t'(ch));
        end
    endgenerate

    assign idx_o = idx;
endmodule

// File: rtl/vdet_flag_bank.sv
module vdet_flag_bank
    import vdet_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  chvec_t sel_i,
    input  logic   flag_i,
    output chvec_t status_o,
    output logic   change_o
);
    bank_state_t st_d, st_q;
    chvec_t      hit;

    always_comb begin
        st_d = st_q;
        hit  = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (wr_en && sel_i[ch]) begin
                st_d.status[ch] = flag_i;
                hit[ch]         = (st_q.status[ch] != flag_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign change_o = |hit;
endmodule

// File: rtl/vdet_irq_gen.sv
module vdet_irq_gen
    import vdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic change_i,
    output logic irq_o
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = change_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/vdet_status_tracker.sv
module vdet_status_tracker
    import vdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_en,
    input  logic        narrow_id,
    input  logic        meta_valid,
    input  logic [4:0]  meta_src,
    input  logic        meta_flag,
    output logic [31:0] status_o,
    output logic        irq_o
);
    src_t   idx;
    chvec_t sel;
    logic   accept;
    logic   change;

    assign accept = meta_valid & mode_en;

    vdet_src_decode u_decode (
        .narrow_id (narrow_id),
        .src_i     (meta_src),
        .idx_o     (idx),
        .sel_o     (sel)
    );

    vdet_flag_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .sel_i    (sel),
        .flag_i   (meta_flag),
        .status_o (status_o),
        .change_o (change)
    );

    vdet_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .change_i (change),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/vdet_status_tracker_chk.sv
module vdet_status_tracker_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_en,
    input logic        narrow_id,
    input logic        meta_valid,
    input logic [4:0]  meta_src,
    input logic        meta_flag,
    input logic [31:0] status_o,
    input logic        irq_o
);
    logic [4:0] exp_idx;
    logic       acc;
    assign exp_idx = narrow_id ? {2'b00, meta_src[2:0]} : meta_src;
    assign acc     = meta_valid & mode_en;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_o == 32'h0) && !irq_o);

    assert_write_bit_R2: assert property (@(posedge clk) disable iff (rst)
        acc |=> status_o[$past(exp_idx)] == $past(meta_flag));

    assert_single_bit_R3: assert property (@(posedge clk) disable iff (rst)
        acc |=> $countones(status_o ^ $past(status_o)) <= 1);

    assert_irq_on_change_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && (status_o[exp_idx] != meta_flag)) |=> irq_o);

    assert_no_irq_same_R5: assert property (@(posedge clk) disable iff (rst)
        (acc && (status_o[exp_idx] == meta_flag)) |=> !irq_o);

    assert_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (meta_valid && !mode_en) |=> $stable(status_o) && !irq_o);

    assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && narrow_id) |=> $stable(status_o[31:8]));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(status_o) && !irq_o);
endmodule

bind vdet_status_tracker vdet_status_tracker_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .narrow_id  (narrow_id),
    .meta_valid (meta_valid),
    .meta_src   (meta_src),
    .meta_flag  (meta_flag),
    .status_o   (status_o),
    .irq_o      (irq_o)
);

// File: tb/vdet_status_tracker_tb.sv
`timescale 1ns/1ps
module vdet_status_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_en = 1'b0;
    logic        narrow_id = 1'b0;
    logic        meta_valid = 1'b0;
    logic [4:0]  meta_src = '0;
    logic        meta_flag = 1'b0;
    logic [31:0] status_o;
    logic        irq_o;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [31:0] mdl = '0;

    always #4 clk = ~clk;

    vdet_status_tracker dut_i (
        .clk(clk), .rst(rst), .mode_en(mode_en), .narrow_id(narrow_id),
        .meta_valid(meta_valid), .meta_src(meta_src), .meta_flag(meta_flag),
        .status_o(status_o), .irq_o(irq_o)
    );

    function automatic logic [4:0] idx_of(input logic [4:0] s, input logic nar);
        return nar ? {2'b00, s[2:0]} : s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, check after the next rising edge.
    task automatic step(input string req, input logic v, input logic en,
                        input logic nar, input logic [4:0] s, input logic f);
        logic exp_irq;
        logic [4:0] ix;
        meta_valid = v; mode_en = en; narrow_id = nar; meta_src = s; meta_flag = f;
        ix = idx_of(s, nar);
        exp_irq = 1'b0;
        if (v && en) begin
            exp_irq = (mdl[ix] != f);
            mdl[ix] = f;
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " status"}, status_o, mdl);
        check({req, " irq"}, {31'b0, irq_o}, {31'b0, exp_irq});
    endtask

    task automatic do_reset();
        rst = 1'b1; meta_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        mdl = '0;
        check("R1 reset status", status_o, 32'h0);
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2/R4: set channel 5, full index
        step("R2 R4 set ch5", 1, 1, 0, 5'd5, 1);
        // R5: same value again, no interrupt
        step("R5 repeat ch5", 1, 1, 0, 5'd5, 1);
        // R9: idle cycle, pulse gone
        step("R9 idle", 0, 1, 0, 5'd0, 0);
        // R8: top channel reachable
        step("R8 ch31", 1, 1, 0, 5'd31, 1);
        step("R8 ch16", 1, 1, 0, 5'd16, 1);
        // R7: upper bits masked, 5'b11010 -> ch2
        step("R7 narrow 26->2", 1, 1, 1, 5'd26, 1);
        step("R7 narrow 29->5 clear", 1, 1, 1, 5'd29, 0);
        // R6: mode disabled ignores strobe
        step("R6 disabled", 1, 0, 0, 5'd9, 1);
        step("R6 disabled narrow", 1, 0, 1, 5'd2, 0);
        // R3/R4: back-to-back toggles on one channel
        step("R4 toggle a", 1, 1, 0, 5'd12, 1);
        step("R4 toggle b", 1, 1, 0, 5'd12, 0);
        step("R4 toggle c", 1, 1, 0, 5'd12, 1);
        step("R3 other ch", 1, 1, 0, 5'd13, 0);

        // R1: reset again with bits set
        do_reset();

        // Random mix covering R2..R9
        for (int i = 0; i < 3000; i++) begin
            logic v, en, nar, f;
            logic [4:0] s;
            v   = ($urandom % 4) != 0;
            en  = ($urandom % 8) != 0;
            nar = $urandom % 2;
            s   = 5'($urandom);
            f   = $urandom % 2;
            step("R2-mix R3 R4 R5 R6 R7 R8 R9 random", v, en, nar, s, f);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule